// File: doc/BRIEF.md
# Coverage-Sampled Antialiasing Resolve

This block turns one antialiased pixel record into a single displayable RGBA8 color. A pixel keeps a few full color slots (four or eight). It also keeps a larger set of coverage samples (four, eight or sixteen). Each coverage sample is a small field: it either names the color slot that the covering triangle wrote, or marks the sample as not covered. Because a triangle is shaded once per pixel and that one color is shared by every sample the triangle covers, many coverage samples point at the same slot. The resolve therefore weights each slot by the number of live coverage samples that refer to it, rather than averaging a color per sample.

The block accepts one pixel record per cycle over a valid/ready input. The record holds a quality mode, the packed coverage fields, the packed color slots and the clear color to use for a pixel with no live coverage. The resolved color leaves through a valid/ready output after a two-register pipeline. Backpressure on the output stalls the pipeline without dropping, repeating or reordering pixels.

Top module: `csaa_resolve`

## Requirements
- R1: `in_mode` selects the quality level: 0 = 4 slots/4 samples, 1 = 4 slots/8 samples, 2 = 8 slots/8 samples, 3 = 4 slots/16 samples, 4 = 8 slots/16 samples; codes 5, 6 and 7 behave exactly as code 0.
- R2: Coverage sample j occupies `in_cov[4j+3:4j]`; bit 3 set marks it uncovered. Otherwise, in the 8-slot modes bits 2:0 name the slot, and in the 4-slot modes bits 1:0 name the slot and bit 2 is ignored.
- R3: Only the first N coverage fields (N from R1) take part; fields at positions N and above have no effect on the result.
- R4: Slot s occupies `in_colors[32s+31:32s]`, and within any 32-bit color the channels sit at bits 7:0 R, 15:8 G, 23:16 B, 31:24 A; each channel is resolved on its own.
- R5: With V live samples (V > 0) and S the sum of one channel over the slots those samples reference, that output channel is floor((S + floor(V/2)) / V), so that a slot weighs by its reference count and halves round upward.
- R6: With no live sample, the output equals the `in_clear` value that entered together with that pixel.
- R7: A pixel accepted at clock edge k, with the output free, shows on `out_valid` after edge k+1; one pixel per cycle is sustained when `out_ready` stays high, and `in_ready` is high whenever `out_valid` is low.
- R8: While `out_valid` is high and `out_ready` low, `out_valid` and `out_rgba` hold; with both stages full `in_ready` is low; pixels leave in arrival order, none lost or repeated.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel record offered |
| in_ready | output | 1 | Pixel record taken this edge when also valid |
| in_mode | input | 3 | Quality mode code (R1) |
| in_cov | input | 64 | Sixteen 4-bit coverage fields (R2) |
| in_colors | input | 256 | Eight 32-bit RGBA color slots (R4) |
| in_clear | input | 32 | Color used when no sample is live (R6) |
| out_valid | output | 1 | Resolved color present |
| out_ready | input | 1 | Consumer takes the resolved color |
| out_rgba | output | 32 | Resolved RGBA8 color |

## Verification
The two functions that meet in one cycle are taking a new record into the first stage and moving the older one into the output register, both on the same edge, while the consumer may or may not take the previous output. Random `in_valid` and `out_ready` with independent densities produce every mix of these, and a bench queue of expected colors, computed from the requirements, judges order and value of each departure. A directed stall fills both stages under held backpressure to check that the output holds and the input closes, then releases it.

// File: rtl/csaa_pkg.sv
package csaa_pkg;

  localparam int MODE_W   = 3;
  localparam int CHANNELS = 4;

  typedef enum logic [MODE_W-1:0] {
    Q_4S4C  = 3'd0,
    Q_4S8C  = 3'd1,
    Q_8S8C  = 3'd2,
    Q_4S16C = 3'd3,
    Q_8S16C = 3'd4
  } quality_e;

  // number of coverage samples that take part in the given quality mode
  function automatic logic [4:0] mode_cov_count(logic [MODE_W-1:0] m);
    logic [4:0] n;
    case (m)
      Q_4S8C, Q_8S8C:   n = 5'd8;
      Q_4S16C, Q_8S16C: n = 5'd16;
      default:          n = 5'd4;
    endcase
    return n;
  endfunction

  // whether the mode addresses eight color slots (three index bits)
  function automatic logic mode_wide_slots(logic [MODE_W-1:0] m);
    return (m == Q_8S8C) || (m == Q_8S16C);
  endfunction

endpackage

// File: rtl/csaa_cov_decode.sv
module csaa_cov_decode #(
  parameter int COVS  = 16,
  parameter int IDX_W = 3,
  localparam int FIELD_W = IDX_W + 1
) (
  input  logic [csaa_pkg::MODE_W-1:0]  mode,
  input  logic [COVS*FIELD_W-1:0]      cov,
  output logic [COVS-1:0]              live,
  output logic [COVS-1:0][IDX_W-1:0]   slot
);
  import csaa_pkg::*;

  logic [4:0] active_n;
  logic       wide;

  assign active_n = mode_cov_count(mode);
  assign wide     = mode_wide_slots(mode);

  for (genvar j = 0; j < COVS; j++) begin : g_sample
    logic [FIELD_W-1:0] fld;
    assign fld = cov[j*FIELD_W +: FIELD_W];
    // top bit of the field flags an uncovered sample
    assign live[j] = !fld[FIELD_W-1] && (j < int'(active_n));
    // narrow modes address four slots, upper index bit forced low
    assign slot[j] = wide ? fld[IDX_W-1:0]
                          : {1'b0, fld[IDX_W-2:0]};
  end

endmodule

// File: rtl/csaa_accum.sv
module csaa_accum #(
  parameter int CH_W  = 8,
  parameter int SLOTS = 8,
  parameter int COVS  = 16,
  localparam int NCH   = csaa_pkg::CHANNELS,
  localparam int PIX_W = NCH * CH_W,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(COVS + 1),
  localparam int SUM_W = CH_W + $clog2(COVS)
) (
  input  logic [COVS-1:0]             live,
  input  logic [COVS-1:0][IDX_W-1:0]  slot,
  input  logic [SLOTS*PIX_W-1:0]      colors,
  output logic [NCH-1:0][SUM_W-1:0]   sum,
  output logic [CNT_W-1:0]            cnt
);

  // each live sample adds the channel values of the slot it names,
  // which is the same as weighting each slot by its reference count
  always_comb begin
    cnt = '0;
    sum = '0;
    for (int j = 0; j < COVS; j++) begin
      if (live[j]) begin
        cnt = cnt + CNT_W'(1);
        for (int c = 0; c < NCH; c++) begin
          sum[c] = sum[c] +
            SUM_W'(colors[int'(slot[j])*PIX_W + c*CH_W +: CH_W]);
        end
      end
    end
  end

endmodule

// File: rtl/csaa_div_round.sv
module csaa_div_round #(
  parameter int CH_W  = 8,
  parameter int SUM_W = 12,
  parameter int CNT_W = 5
) (
  input  logic [SUM_W-1:0] sum,
  input  logic [CNT_W-1:0] cnt,
  output logic [CH_W-1:0]  q
);
  localparam int NUM_W = SUM_W + 1;

  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] den;
  logic [NUM_W-1:0] quo;

  // add half the divisor so that the quotient rounds half upward
  assign num = {1'b0, sum} + NUM_W'(cnt >> 1);
  assign den = NUM_W'(cnt);
  assign quo = (den == '0) ? '0 : num / den;
  // the average never exceeds a channel maximum; clamp keeps width honest
  assign q   = (|quo[NUM_W-1:CH_W]) ? '1 : quo[CH_W-1:0];

endmodule

// File: rtl/csaa_resolve.sv
module csaa_resolve #(
  parameter int CH_W  = 8,
  parameter int SLOTS = 8,
  parameter int COVS  = 16,
  localparam int NCH     = csaa_pkg::CHANNELS,
  localparam int PIX_W   = NCH * CH_W,
  localparam int IDX_W   = $clog2(SLOTS),
  localparam int FIELD_W = IDX_W + 1,
  localparam int CNT_W   = $clog2(COVS + 1),
  localparam int SUM_W   = CH_W + $clog2(COVS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [csaa_pkg::MODE_W-1:0]   in_mode,
  input  logic [COVS*FIELD_W-1:0]       in_cov,
  input  logic [SLOTS*PIX_W-1:0]        in_colors,
  input  logic [PIX_W-1:0]              in_clear,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [PIX_W-1:0]              out_rgba
);

  // ---------------- decode and accumulate (feeds stage 1) ----------------
  logic [COVS-1:0]             live;
  logic [COVS-1:0][IDX_W-1:0]  slot;
  logic [NCH-1:0][SUM_W-1:0]   acc_sum;
  logic [CNT_W-1:0]            acc_cnt;

  csaa_cov_decode #(.COVS(COVS), .IDX_W(IDX_W)) u_decode (
    .mode (in_mode),
    .cov  (in_cov),
    .live (live),
    .slot (slot)
  );

  csaa_accum #(.CH_W(CH_W), .SLOTS(SLOTS), .COVS(COVS)) u_accum (
    .live   (live),
    .slot   (slot),
    .colors (in_colors),
    .sum    (acc_sum),
    .cnt    (acc_cnt)
  );

  // ---------------- pipeline control ----------------
  logic                       s1_vld;
  logic [NCH-1:0][SUM_W-1:0]  s1_sum;
  logic [CNT_W-1:0]           s1_cnt;
  logic [PIX_W-1:0]           s1_clear;
  logic                       s2_take;
  logic                       out_vld_q;
  logic [PIX_W-1:0]           out_rgba_q;

  assign s2_take  = !out_vld_q || out_ready;
  assign in_ready = !s1_vld || s2_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld    <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      if (in_ready) s1_vld    <= in_valid;
      if (s2_take)  out_vld_q <= s1_vld;
    end
  end

  // stage 1: weighted sums, live count and the pixel's clear color
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_sum   <= '0;
      s1_cnt   <= '0;
      s1_clear <= '0;
    end else if (in_valid && in_ready) begin
      s1_sum   <= acc_sum;
      s1_cnt   <= acc_cnt;
      s1_clear <= in_clear;
    end
  end

  // ---------------- stage 2: rounded divide per channel ----------------
  logic [PIX_W-1:0] div_rgba;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    csaa_div_round #(.CH_W(CH_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_div (
      .sum (s1_sum[c]),
      .cnt (s1_cnt),
      .q   (div_rgba[c*CH_W +: CH_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_rgba_q <= '0;
    end else if (s2_take && s1_vld) begin
      out_rgba_q <= (s1_cnt == '0) ? s1_clear : div_rgba;
    end
  end

  assign out_valid = out_vld_q;
  assign out_rgba  = out_rgba_q;

endmodule

// File: rtl/csaa_resolve_chk.sv
module csaa_resolve_chk #(
  parameter int PIX_W = 32,
  parameter int CNT_W = 5,
  parameter int COVS  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_rgba,
  input logic             s1_vld,
  input logic [CNT_W-1:0] s1_cnt,
  input logic [PIX_W-1:0] s1_clear
);

  logic out_free;
  assign out_free = !out_valid || out_ready;

  // R8: a stalled output keeps its flag and its color
  a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgba)));

  // R8: both stages full under backpressure close the input
  a_r8_input_closed: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && s1_vld) |-> !in_ready);

  // R7: an empty output always lets a new record in
  a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R7: a new output only appears from an occupied first stage
  a_r7_output_source: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !s1_vld) |=> !out_valid);

  // R6: a pixel with no live sample resolves to its own clear color
  a_r6_clear_on_empty: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && out_free && s1_cnt == '0) |=> (out_rgba == $past(s1_clear)));

  // R3: the live count never exceeds the coverage sample count
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> (int'(s1_cnt) <= COVS));

  // R8: nothing is offered while the input is ignored (no lost accept)
  a_r8_no_phantom: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !s1_vld && !out_valid) |=> !s1_vld);

endmodule

bind csaa_resolve csaa_resolve_chk #(
  .PIX_W (PIX_W),
  .CNT_W (CNT_W),
  .COVS  (COVS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rgba  (out_rgba),
  .s1_vld    (s1_vld),
  .s1_cnt    (s1_cnt),
  .s1_clear  (s1_clear)
);

// File: tb/csaa_resolve_test.sv
module csaa_resolve_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_mode = '0;
  logic [63:0]  in_cov = '0;
  logic [255:0] in_colors = '0;
  logic [31:0]  in_clear = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [31:0]  out_rgba;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;   // 250 MHz

  csaa_resolve uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_cov(in_cov),
    .in_colors(in_colors), .in_clear(in_clear),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgba(out_rgba)
  );

  // expected color straight from R1..R6
  function automatic logic [31:0] model(logic [2:0] m, logic [63:0] cov,
                                        logic [255:0] col, logic [31:0] clr);
    int n, v, s;
    int sum[4];
    bit wide;
    logic [3:0] f;
    logic [31:0] r;
    n = (m == 3'd1 || m == 3'd2) ? 8 : (m == 3'd3 || m == 3'd4) ? 16 : 4;
    wide = (m == 3'd2 || m == 3'd4);
    v = 0;
    for (int c = 0; c < 4; c++) sum[c] = 0;
    for (int j = 0; j < n; j++) begin
      f = cov[4*j +: 4];
      if (!f[3]) begin
        s = wide ? int'(f[2:0]) : int'(f[1:0]);
        v++;
        for (int c = 0; c < 4; c++) sum[c] += int'(col[32*s + 8*c +: 8]);
      end
    end
    if (v == 0) return clr;
    for (int c = 0; c < 4; c++) r[8*c +: 8] = 8'((sum[c] + v/2) / v);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle: drive at the falling edge, then judge the coming rising edge
  task automatic cycle(bit v, bit ordy, logic [2:0] m, logic [63:0] cov,
                       logic [255:0] col, logic [31:0] clr, string tag,
                       output bit acc);
    @(negedge clk);
    in_valid = v; out_ready = ordy; in_mode = m;
    in_cov = cov; in_colors = col; in_clear = clr;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R8", out_rgba, 32'hxxxxxxxx);
      else begin
        string t;
        logic [31:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_rgba, e);
      end
    end
    acc = v && in_ready;
    if (acc) begin
      exp_q.push_back(model(m, cov, col, clr));
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(logic [2:0] m, logic [63:0] cov, logic [255:0] col,
                      logic [31:0] clr, string tag);
    bit acc = 0;
    while (!acc) cycle(1'b1, 1'b1, m, cov, col, clr, tag, acc);
  endtask

  task automatic idle(int n);
    bit acc;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b1, 3'd0, '0, '0, '0, "idle", acc);
  endtask

  function automatic logic [63:0] rand_cov();
    logic [63:0] c;
    for (int j = 0; j < 16; j++)
      c[4*j +: 4] = (($urandom % 4) == 0) ? 4'(8 + $urandom % 8) : 4'($urandom % 8);
    return c;
  endfunction

  function automatic logic [255:0] rand_col();
    logic [255:0] c;
    for (int k = 0; k < 8; k++) c[32*k +: 32] = $urandom;
    return c;
  endfunction

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit acc;
    logic [255:0] col;
    logic [63:0]  cov;
    logic [31:0]  held;
    void'($urandom(32'd2024));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9: state right after reset
    check("R9", {31'd0, out_valid}, 32'd0);
    check("R9", {31'd0, in_ready}, 32'd1);

    // R6: every field uncovered in each mode
    for (int m = 0; m < 5; m++)
      send(3'(m), {16{4'hF}}, rand_col(), 32'h11223344 + m, "R6");
    // R3: only fields beyond the active count are covered
    col = rand_col();
    send(3'd0, {{12{4'h7}}, {4{4'h8}}}, col, 32'hCAFE0001, "R3");
    send(3'd1, {{8{4'h3}}, {8{4'hC}}}, col, 32'hCAFE0002, "R3");
    // R2: bit 2 ignored in four-slot modes, honoured in eight-slot modes
    send(3'd3, {16{4'h5}}, col, '0, "R2");
    send(3'd4, {16{4'h5}}, col, '0, "R2");
    // R1: reserved codes act as the four-sample mode
    for (int m = 5; m < 8; m++) send(3'(m), rand_cov(), rand_col(), '0, "R1");
    // R4: channels with distinct values per slot
    for (int k = 0; k < 8; k++) col[32*k +: 32] = {8'(k*30+3), 8'(255-k), 8'(k*7), 8'(k)};
    send(3'd4, 64'h7654321076543210, col, '0, "R4");
    // R5: rounding of thirds and halves
    col = '0; col[7:0] = 8'd2; col[39:32] = 8'd1;
    send(3'd2, {{13{4'hF}}, 4'h1, 4'h1, 4'h0}, col, '0, "R5");
    send(3'd2, {{14{4'hF}}, 4'h1, 4'h0}, col, '0, "R5");
    send(3'd2, {{13{4'hF}}, 4'h0, 4'h0, 4'h1}, col, '0, "R5");
    idle(4);

    // R7: latency into an empty pipeline
    send(3'd3, rand_cov(), rand_col(), '0, "R7");
    cycle(1'b0, 1'b1, 3'd0, '0, '0, '0, "idle", acc);
    check("R7", {31'd0, out_valid}, 32'd0);
    cycle(1'b0, 1'b1, 3'd0, '0, '0, '0, "idle", acc);
    check("R7", {31'd0, out_valid}, 32'd1);
    idle(3);

    // R8: fill both stages under held backpressure
    cycle(1'b1, 1'b0, 3'd4, rand_cov(), rand_col(), '0, "R8", acc);
    cycle(1'b1, 1'b0, 3'd1, rand_cov(), rand_col(), '0, "R8", acc);
    cycle(1'b1, 1'b0, 3'd2, rand_cov(), rand_col(), '0, "R8", acc);
    held = out_rgba;
    for (int i = 0; i < 4; i++) begin
      cycle(1'b1, 1'b0, 3'd0, rand_cov(), rand_col(), '0, "R8", acc);
      check("R8", {31'd0, out_valid}, 32'd1);
      check("R8", out_rgba, held);
      check("R8", {31'd0, in_ready}, 32'd0);
    end
    idle(4);

    // R5: random traffic with random stalls on both sides
    for (int i = 0; i < 3000; i++) begin
      cov = rand_cov();
      cycle(($urandom % 10) < 7, ($urandom % 4) != 0, 3'($urandom % 8),
            cov, rand_col(), $urandom, "R5", acc);
    end
    idle(6);
    // R8: every accepted pixel has left
    check("R8", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule